// File: doc/BRIEF.md
# Core Clock Source Selection Chain

This block forms the internal core clock bus from an external input clock and two free-running on-chip oscillators. The oscillators are a slow programmable-delay one and a fast ring one. The selection is a fixed chain of three two-way stages followed by an optional divide-by-two. Each stage and the divider bypass is steered by its own configuration bit, so the source, a single-step mode and the division are chosen independently of each other. One further bit chooses whether the clock output pin shows the external input or the internal bus.

The configuration bits sit in a small register file written one bit at a time. Writes use a bit address and a one-bit value, synchronous to a separate register-interface clock. Five further bits drive scan-column enables and play no part in the clock path. The oscillators are treated as ordinary clock inputs.

Top module: `clk_sel_chain`

## Requirements
- R1: Configuration bit 4 selects the first stage source: clear passes `ext_clk_i`, set passes `slow_osc_i`.
- R2: With configuration bit 1 set (and bit 2 clear), the current value of configuration bit 0 becomes the pre-divider clock, so each write of bit 0 steps the clock by hand.
- R3: With configuration bit 2 set, `fast_osc_i` drives the pre-divider clock regardless of bits 4, 1 and 0.
- R4: With configuration bit 3 clear, `core_clk_o` toggles once per rising edge of the pre-divider clock (half frequency, 50% duty). With bit 3 set, `core_clk_o` equals the pre-divider clock.
- R5: Configuration bit 6 clear makes `out_clk_o` follow `ext_clk_i`; set makes `out_clk_o` follow `core_clk_o`.
- R6: Configuration bit 5 is reserved: setting it changes neither output clock nor `scan_col_en_o`.
- R7: Configuration bits 7 to 11 drive `scan_col_en_o[0]` to `scan_col_en_o[4]` in that order; they do not affect `core_clk_o` or `out_clk_o`.
- R8: While `rst_ni` is low (asynchronously), all configuration bits are clear, `core_clk_o` is low and `scan_col_en_o` is zero. After reset the path is external clock divided by two, and the pin shows the external clock.
- R9: On a rising `reg_clk_i` edge with `cfg_we_i` high, the bit at `cfg_addr_i` takes `cfg_wdata_i`; with `cfg_we_i` low, no bit changes.
- R10: Writes to addresses 12 to 15 change no configuration bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| reg_clk_i | input | 1 | Register-interface clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cfg_we_i | input | 1 | Configuration bit write enable |
| cfg_addr_i | input | 4 | Configuration bit address |
| cfg_wdata_i | input | 1 | Value written to the addressed bit |
| ext_clk_i | input | 1 | External input clock |
| slow_osc_i | input | 1 | Slow programmable-delay oscillator output |
| fast_osc_i | input | 1 | Fast ring oscillator output |
| core_clk_o | output | 1 | Internal core clock bus |
| out_clk_o | output | 1 | Clock output pin |
| scan_col_en_o | output | 5 | Scan-column enables |

## Verification
Edges of both output clocks are counted over fixed windows, and the source and division ratio are inferred from the counts. Precedence is probed by setting bits that should lose. A design whose fast stage sat before the step or slow stage would report the slow rate or a frozen clock instead of the fast count. Single-step is exercised with the divider both bypassed and in use; a design that divided on both edges or ignored bit 0 would show 4 toggles instead of 2, or none. Writes are tried with enable low, to the reserved bit and to the unused addresses; a design with a broken decoder would then change the counts or light a scan enable.

// File: rtl/clk_chain_pkg.sv
package clk_chain_pkg;
  localparam int CFG_N      = 12;
  localparam int CFG_AW     = $clog2(CFG_N + 1);
  localparam int B_STEP_VAL = 0;
  localparam int B_STEP_EN  = 1;
  localparam int B_FAST     = 2;
  localparam int B_NODIV    = 3;
  localparam int B_SLOW     = 4;
  localparam int B_RSVD     = 5;
  localparam int B_OUT_INT  = 6;
  localparam int B_SCAN_LO  = 7;
  localparam int SCAN_N     = CFG_N - B_SCAN_LO;
  localparam int STAGE_N    = 3;

  // Select bit of each chain stage, in chain order.
  function automatic int stage_sel(input int idx);
    case (idx)
      0:       return B_SLOW;
      1:       return B_STEP_EN;
      default: return B_FAST;
    endcase
  endfunction
endpackage

// File: rtl/clk_cfg_regs.sv
module clk_cfg_regs #(
  parameter int N  = 12,
  parameter int AW = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [AW-1:0] addr_i,
  input  logic          wdata_i,
  output logic [N-1:0]  cfg_o
);
  logic [N-1:0] cfg_q;

  for (genvar g = 0; g < N; g++) begin : g_bit
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                             cfg_q[g] <= 1'b0;
      else if (we_i && addr_i == AW'(g))       cfg_q[g] <= wdata_i;
    end
  end

  assign cfg_o = cfg_q;

  assert_write_lands_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && int'(addr_i) < N) |=> cfg_q[$past(addr_i)] == $past(wdata_i));

  assert_idle_holds_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_i |=> $stable(cfg_q));

  assert_high_addr_ignored_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && int'(addr_i) >= N) |=> $stable(cfg_q));
endmodule

// File: rtl/clk_stage_mux.sv
module clk_stage_mux (
  input  logic prev_i,
  input  logic alt_i,
  input  logic sel_i,
  output logic clk_o
);
  assign clk_o = sel_i ? alt_i : prev_i;
endmodule

// File: rtl/clk_div2.sv
module clk_div2 (
  input  logic clk_i,
  input  logic rst_ni,
  output logic clk_o
);
  logic q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q <= 1'b0;
    else         q <= ~q;
  end

  assign clk_o = q;

  assert_div_toggles_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_ni |=> clk_o != $past(clk_o));
endmodule

// File: rtl/clk_sel_chain.sv
module clk_sel_chain
  import clk_chain_pkg::*;
(
  input  logic                reg_clk_i,
  input  logic                rst_ni,
  input  logic                cfg_we_i,
  input  logic [CFG_AW-1:0]   cfg_addr_i,
  input  logic                cfg_wdata_i,
  input  logic                ext_clk_i,
  input  logic                slow_osc_i,
  input  logic                fast_osc_i,
  output logic                core_clk_o,
  output logic                out_clk_o,
  output logic [SCAN_N-1:0]   scan_col_en_o
);
  logic [CFG_N-1:0]   cfg;
  logic [STAGE_N:0]   chain;
  logic [STAGE_N-1:0] alt_src;
  logic               div_clk;
  logic               unused_rsvd;

  clk_cfg_regs #(.N(CFG_N), .AW(CFG_AW)) i_regs (
    .clk_i   (reg_clk_i),
    .rst_ni  (rst_ni),
    .we_i    (cfg_we_i),
    .addr_i  (cfg_addr_i),
    .wdata_i (cfg_wdata_i),
    .cfg_o   (cfg)
  );

  // Stage order is fixed: later stages override earlier ones.
  assign chain[0] = ext_clk_i;
  assign alt_src  = {fast_osc_i, cfg[B_STEP_VAL], slow_osc_i};

  for (genvar g = 0; g < STAGE_N; g++) begin : g_stage
    clk_stage_mux i_mux (
      .prev_i (chain[g]),
      .alt_i  (alt_src[g]),
      .sel_i  (cfg[stage_sel(g)]),
      .clk_o  (chain[g+1])
    );
  end

  clk_div2 i_div (
    .clk_i  (chain[STAGE_N]),
    .rst_ni (rst_ni),
    .clk_o  (div_clk)
  );

  clk_stage_mux i_bypass (
    .prev_i (div_clk),
    .alt_i  (chain[STAGE_N]),
    .sel_i  (cfg[B_NODIV]),
    .clk_o  (core_clk_o)
  );

  clk_stage_mux i_pin (
    .prev_i (ext_clk_i),
    .alt_i  (core_clk_o),
    .sel_i  (cfg[B_OUT_INT]),
    .clk_o  (out_clk_o)
  );

  assign scan_col_en_o = cfg[CFG_N-1:B_SCAN_LO];
  assign unused_rsvd   = cfg[B_RSVD];
endmodule

// File: tb/test_clk_sel_chain.sv
`timescale 1ns/100ps
module test_clk_sel_chain;
  import clk_chain_pkg::*;

  typedef struct {
    int    core_exp;
    int    out_exp;
    string tag;
  } win_item_t;

  logic reg_clk = 0, rst_ni = 0, we = 0, wdata = 0;
  logic [CFG_AW-1:0] addr = '0;
  logic ext_clk = 0, slow_osc = 0, fast_osc = 0;
  logic core_clk, out_clk;
  logic [SCAN_N-1:0] scan;

  int checks = 0, failures = 0;
  int core_tog = 0, out_tog = 0;
  bit done = 0;
  win_item_t sb_q[$];
  event win_open, win_done;

  clk_sel_chain i_clk_sel_chain (
    .reg_clk_i(reg_clk), .rst_ni(rst_ni), .cfg_we_i(we), .cfg_addr_i(addr),
    .cfg_wdata_i(wdata), .ext_clk_i(ext_clk), .slow_osc_i(slow_osc),
    .fast_osc_i(fast_osc), .core_clk_o(core_clk), .out_clk_o(out_clk),
    .scan_col_en_o(scan)
  );

  always #10 ext_clk = ~ext_clk;               // 50 MHz
  always #20 slow_osc = ~slow_osc;
  always #4  fast_osc = ~fast_osc;
  initial begin #5; forever #10 reg_clk = ~reg_clk; end

  always @(core_clk) core_tog++;
  always @(out_clk)  out_tog++;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wr(input int a, input bit d);
    @(negedge reg_clk);
    we = 1; addr = CFG_AW'(a); wdata = d;
    @(negedge reg_clk);
    we = 0;
  endtask

  // Driver: push expectation, wait for the window to close.
  task automatic measure(input int ce, input int oe, input string tag);
    win_item_t it;
    it.core_exp = ce; it.out_exp = oe; it.tag = tag;
    sb_q.push_back(it);
    @(win_done);
  endtask

  // Monitor: open a 400 ns window aligned clear of all clock edges.
  initial begin
    forever begin
      win_item_t it;
      wait (sb_q.size() != 0);
      it = sb_q.pop_front();
      @(posedge slow_osc); #1;
      core_tog = 0; out_tog = 0;
      ->win_open;
      #400;
      check(core_tog == it.core_exp, {it.tag, " core"}, core_tog, it.core_exp);
      check(out_tog == it.out_exp, {it.tag, " pin"}, out_tog, it.out_exp);
      ->win_done;
    end
  end

  initial begin
    #1000000;
    if (!done) begin
      failures++; checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    #3;
    check(core_clk == 1'b0, "R8 core low in reset", int'(core_clk), 0);
    check(scan == '0, "R8 scan clear in reset", int'(scan), 0);
    #100; rst_ni = 1;
    measure(20, 40, "R8 default ext/2");

    wr(4, 1); measure(10, 40, "R1 slow /2");
    wr(3, 1); measure(20, 40, "R1 slow undivided");
    wr(4, 0); measure(40, 40, "R4 ext undivided");
    wr(6, 1); measure(40, 40, "R5 pin follows core");
    wr(3, 0); measure(20, 20, "R5 pin follows core /2");
    wr(6, 0);

    wr(2, 1); measure(50, 40, "R3 fast /2");
    wr(3, 1); measure(100, 40, "R3 fast undivided");
    wr(4, 1); measure(100, 40, "R3 fast beats slow");
    wr(1, 1); measure(100, 40, "R3 fast beats step");
    wr(2, 0); wr(4, 0);

    // Single-step, undivided: 4 writes of bit 0 -> 4 toggles.
    fork
      measure(4, 40, "R2 step undivided");
      begin @(win_open); wr(0, 1); wr(0, 0); wr(0, 1); wr(0, 0); end
    join
    wr(3, 0);
    fork
      measure(2, 40, "R2 step divided");
      begin @(win_open); wr(0, 1); wr(0, 0); wr(0, 1); wr(0, 0); end
    join
    wr(1, 0);

    wr(5, 1); measure(20, 40, "R6 reserved no effect");
    #1 check(scan == '0, "R6 scan unchanged", int'(scan), 0);

    @(negedge reg_clk); we = 0; addr = CFG_AW'(3); wdata = 1;
    @(negedge reg_clk); wdata = 0;
    measure(20, 40, "R9 enable low ignored");

    for (int a = CFG_N; a < (1 << CFG_AW); a++) wr(a, 1);
    measure(20, 40, "R10 high addresses ignored");
    #1 check(scan == '0, "R10 scan unchanged", int'(scan), 0);

    wr(7, 1); wr(9, 1);
    #1 check(scan == 5'b00101, "R7 scan lanes 0 and 2", int'(scan), 5);
    measure(20, 40, "R7 core unaffected");
    wr(11, 1);
    #1 check(scan == 5'b10101, "R7 scan lane 4", int'(scan), 21);

    wr(3, 1); wr(6, 1);
    @(negedge reg_clk); #2 rst_ni = 0; #3;
    check(core_clk == 1'b0, "R8 core low on async reset", int'(core_clk), 0);
    check(scan == '0, "R8 scan cleared on async reset", int'(scan), 0);
    #40 rst_ni = 1;
    measure(20, 40, "R8 defaults after reset");

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule